// File: doc/BRIEF.md
# Alternating-Turn Obstacle Steering Controller

This block steers a robot that drives in a straight line. A single sensing input says whether something blocks the path. While it is blocked, the controller issues a turn command. Each new blockage is turned away from in the opposite direction to the previous one: right, then left, then right again.

The controller is a four-state Mealy machine with a two-bit state register. The steering command is formed combinationally from the present state and the sensing input. The present state is also driven to a port, so the surrounding logic and the bench can observe it.

Top module: `turn_alternator`

## Requirements
- R1: While `clr` is high at a rising edge of `clk`, the state becomes IDLE_L, code 2'b00. With `blocked` low in IDLE_L, both `steer_left` and `steer_right` are 0.
- R2: In state IDLE_L (00), `blocked`=0 keeps the state at 00 with no turn. `blocked`=1 moves it to TURN_R (01) and drives `steer_right`=1 in that same cycle.
- R3: In TURN_R (01), `blocked`=1 holds the state with `steer_right`=1. `blocked`=0 moves it to IDLE_R (11) with no turn.
- R4: In IDLE_R (11), `blocked`=0 holds the state with no turn. `blocked`=1 moves it to TURN_L (10) and drives `steer_left`=1 in that same cycle.
- R5: In TURN_L (10), `blocked`=1 holds the state with `steer_left`=1. `blocked`=0 moves it to IDLE_L (00) with no turn.
- R6: `steer_left` and `steer_right` are never both 1.
- R7: The outputs are Mealy outputs. When `blocked` is 0, neither steer output is asserted, whatever the state. When `blocked` is 1, `steer_left` equals state bit 1 and `steer_right` equals its inverse.
- R8: Obstacle episodes are the runs of consecutive cycles with `blocked`=1. Successive episodes after a clear are turned right, left, right, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear, active high, to IDLE_L |
| blocked | input | 1 | 1 when an obstacle is in the path |
| steer_left | output | 1 | Turn-left command (first command bit) |
| steer_right | output | 1 | Turn-right command (second command bit) |
| state_code | output | 2 | Present-state code, observation only |

## Verification
Clear and an obstacle can fall in the same cycle. The outputs then follow the old state, and the next state is still IDLE_L. The bench provokes this by raising `clr` while `blocked` is high in TURN_L and in IDLE_R. It judges the steer outputs of that cycle against the old state, and the code one edge later against 00. Random runs also end an episode and begin the next one in adjacent cycles, which checks that the turn memory flips exactly at the episode boundary.

// File: rtl/turn_alt_pkg.sv
package turn_alt_pkg;
  typedef enum logic [1:0] {
    IDLE_L = 2'b00,
    TURN_R = 2'b01,
    TURN_L = 2'b10,
    IDLE_R = 2'b11
  } turn_state_e;

  // Next state, from the transition rules.
  function automatic turn_state_e next_of(input turn_state_e s, input logic obst);
    case (s)
      IDLE_L:  next_of = obst ? TURN_R : IDLE_L;
      TURN_R:  next_of = obst ? TURN_R : IDLE_R;
      IDLE_R:  next_of = obst ? TURN_L : IDLE_R;
      default: next_of = obst ? TURN_L : IDLE_L;
    endcase
  endfunction

  // Command bits {left,right}.
  function automatic logic [1:0] cmd_of(input turn_state_e s, input logic obst);
    cmd_of = obst ? {s[1], ~s[1]} : 2'b00;
  endfunction
endpackage

// File: rtl/turn_alt_next.sv
module turn_alt_next
  import turn_alt_pkg::*;
(
  input  turn_state_e cur,
  input  logic        obst,
  output turn_state_e nxt
);
  always_comb nxt = next_of(cur, obst);
endmodule

// File: rtl/turn_alt_out.sv
module turn_alt_out
  import turn_alt_pkg::*;
(
  input  turn_state_e cur,
  input  logic        obst,
  output logic        go_left,
  output logic        go_right
);
  logic [1:0] cmd;
  always_comb begin
    cmd      = cmd_of(cur, obst);
    go_left  = cmd[1];
    go_right = cmd[0];
  end
endmodule

// File: rtl/turn_alternator.sv
module turn_alternator
  import turn_alt_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       blocked,
  output logic       steer_left,
  output logic       steer_right,
  output logic [1:0] state_code
);
  turn_state_e cur_q, nxt_w;
  logic        seen_rst;

  turn_alt_next u_next (.cur(cur_q), .obst(blocked), .nxt(nxt_w));
  turn_alt_out  u_out  (.cur(cur_q), .obst(blocked), .go_left(steer_left), .go_right(steer_right));

  always_ff @(posedge clk) begin
    if (clr) cur_q <= IDLE_L;
    else     cur_q <= nxt_w;
  end

  always_ff @(posedge clk) begin
    if (clr) seen_rst <= 1'b1;
  end

  assign state_code = cur_q;

  // Named event wires for the assertions.
  wire episode_end = (cur_q == TURN_R || cur_q == TURN_L) && !blocked;
  wire turning     = steer_left | steer_right;

  assert_clear_R1: assert property (@(posedge clk) clr |=> state_code == 2'b00);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (clr || seen_rst !== 1'b1)
    !(steer_left && steer_right));

  assert_mealy_idle_R7: assert property (@(posedge clk) disable iff (clr || seen_rst !== 1'b1)
    !blocked |-> !turning);

  assert_enter_right_R2: assert property (@(posedge clk) disable iff (clr || seen_rst !== 1'b1)
    (state_code == 2'b00 && blocked) |=> state_code == 2'b01);

  assert_enter_left_R4: assert property (@(posedge clk) disable iff (clr || seen_rst !== 1'b1)
    (state_code == 2'b11 && blocked) |=> state_code == 2'b10);

  assert_flip_memory_R8: assert property (@(posedge clk) disable iff (clr || seen_rst !== 1'b1)
    episode_end |=> state_code[1] != $past(state_code[1]));
endmodule

// File: tb/test_turn_alternator.sv
module test_turn_alternator;
  logic clk = 0, clr = 1, blocked = 0;
  logic steer_left, steer_right;
  logic [1:0] state_code;
  int checks = 0, failures = 0;
  logic [1:0] m_state;        // bench model state
  logic       last_right;     // episode direction model
  logic       in_episode;
  logic       wd_expired = 0;

  turn_alternator i_turn_alternator (.clk(clk), .clr(clr), .blocked(blocked),
    .steer_left(steer_left), .steer_right(steer_right), .state_code(state_code));

  always #5 clk = ~clk;

  function automatic logic [1:0] exp_next(input logic [1:0] s, input logic x);
    if (!x) return (s == 2'b01) ? 2'b11 : (s == 2'b10) ? 2'b00 : s;
    return (s == 2'b00) ? 2'b01 : (s == 2'b11) ? 2'b10 : s;
  endfunction

  function automatic logic [1:0] exp_cmd(input logic [1:0] s, input logic x);
    if (!x) return 2'b00;
    return (s == 2'b00 || s == 2'b01) ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply x for one cycle, check combinational outputs then next state.
  task automatic step(input logic x, input logic c, input string req);
    logic [1:0] nx;
    blocked = x; clr = c;
    #2;
    chk(req, {2'b0, steer_left, steer_right}, {2'b0, exp_cmd(m_state, x)});
    chk("R6", {3'b0, steer_left & steer_right}, 4'h0);
    if (x && !in_episode) begin
      chk("R8", {3'b0, steer_right}, {3'b0, ~last_right});
      last_right = ~last_right;
    end
    in_episode = x;
    nx = c ? 2'b00 : exp_next(m_state, x);
    if (c) begin last_right = 1'b0; in_episode = 1'b0; end
    @(posedge clk); #3;
    m_state = nx;
    chk(req, {2'b0, state_code}, {2'b0, m_state});
  endtask

  initial begin
    #1_000_000;
    wd_expired = 1;
  end

  initial begin
    void'($urandom(32'd7));
    m_state = 2'b00; last_right = 1'b0; in_episode = 1'b0;
    @(posedge clk); #3; @(posedge clk); #3;
    clr = 0;
    chk("R1", {2'b0, state_code}, 4'h0);
    #2 chk("R1", {2'b0, steer_left, steer_right}, 4'h0);
    // Directed walk through every arc.
    step(0, 0, "R2"); step(1, 0, "R2"); step(1, 0, "R3"); step(0, 0, "R3");
    step(0, 0, "R4"); step(1, 0, "R4"); step(1, 0, "R5"); step(0, 0, "R5");
    step(0, 0, "R7");
    // Clear colliding with an obstacle, in TURN_L and in IDLE_R.
    step(1, 0, "R8"); step(0, 0, "R8"); step(1, 0, "R4");
    step(1, 1, "R1");
    step(0, 0, "R1"); step(1, 0, "R2"); step(0, 0, "R3");
    step(1, 1, "R1");
    step(0, 0, "R1");
    // Random episodes.
    for (int i = 0; i < 3000 && !wd_expired; i++) begin
      logic x;
      x = ($urandom % 3) != 0;
      step(x, ($urandom % 200) == 0, "R7");
    end
    if (wd_expired) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule